// File: doc/BRIEF.md
# ADC Scan Timing Sequencer

This block walks an analog-to-digital converter through one pass over a set of enabled input channels. It splits the work for each channel into timed phases and counts converter clock cycles for each one. A start request comes from software or from a hardware timer. The sequencer then waits a fixed start-up delay that depends on the source, runs an optional diagnosis conversion, and visits every enabled channel. It closes the pass with fixed end phases and a done pulse.

For each channel the order is: an optional dedicated hold-capture phase followed by a fixed settling wait, an optional line-break assist phase, the sampling window, and a fixed successive-approximation window. The analog front end only sees one-cycle strobes that mark the start of hold capture, sampling and conversion. A result-valid pulse, tagged with the channel number, marks the end of each conversion. All lengths are read from configuration inputs. The channel mask and the hold and diagnosis enables are captured when the scan starts. Count inputs are expected to stay stable during a scan.

Top module: `adc_scan_seq`

## Requirements
- R1: A start request is taken only while `busy` is low. `busy` is high from the cycle after the accepting edge through the cycle in which `done` pulses, and low in the cycle after that. A request while busy, including one in the `done` cycle, starts nothing.
- R2: The first phase begins 6 cycles after acceptance when `sync_trig` is high at that edge, and 4 cycles after it when only `sw_trig` is high. `sync_trig` wins when both are high.
- R3: With `diag_en` high at acceptance, a diagnosis sampling phase of `diag_cfg` cycles (0 counts as 1) and a 32-cycle conversion come before any channel. The last conversion cycle pulses `res_valid` with `res_diag` high.
- R4: Enabled channels are converted in ascending index order. Channels whose bit in `ch_en` (captured at acceptance) is clear cost no cycles.
- R5: The sampling phase of channel n lasts `spl_cfg[8n+7:8n]` cycles (0 counts as 1), and `samp_stb` is high in its first cycle.
- R6: When `ref_en` is high, channel `ref_ch` samples for exactly 15 cycles, whatever its `spl_cfg` byte holds.
- R7: Every conversion lasts 32 cycles. `conv_stb` is high in its first cycle, and `res_valid` is high in its last cycle with `res_ch` equal to the channel and `res_diag` low.
- R8: With `sh_en` high at acceptance, each channel starts with a hold phase of `sh_cfg` cycles (0 counts as 1), flagged by `hold_stb` in its first cycle, followed by a 13-cycle wait. A 3-cycle hold-end phase follows the last converted channel.
- R9: A nonzero `dis_cfg` inserts `dis_cfg` cycles just before each channel's sampling phase. Zero inserts none.
- R10: A 3-cycle end phase closes every scan, and `done` is high in its last cycle. With no channel enabled and diagnosis off, a scan is the start delay plus this phase.
- R11: At most one of `hold_stb`, `samp_stb`, `conv_stb`, `res_valid`, `done` is high in any cycle, and none is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NCH | Channel enable mask |
| spl_cfg | input | NCH*8 | Sampling count per channel, byte n for channel n |
| ref_en | input | 1 | Forces the reference channel's sampling length |
| ref_ch | input | IW | Index of the reference channel |
| sh_en | input | 1 | Enables dedicated hold capture |
| sh_cfg | input | 8 | Hold capture count |
| dis_cfg | input | 4 | Line-break assist count, 0 skips |
| diag_en | input | 1 | Enables the leading diagnosis conversion |
| diag_cfg | input | 8 | Diagnosis sampling count |
| sw_trig | input | 1 | Software start request |
| sync_trig | input | 1 | Synchronous hardware start request |
| busy | output | 1 | Scan in progress |
| hold_stb | output | 1 | First cycle of hold capture |
| samp_stb | output | 1 | First cycle of sampling |
| conv_stb | output | 1 | First cycle of conversion |
| res_valid | output | 1 | Last cycle of a conversion |
| res_diag | output | 1 | Current conversion is the diagnosis one |
| res_ch | output | IW | Channel being processed |
| done | output | 1 | Last cycle of the scan |

## Verification
A new start request can land in the same cycle as the `done` pulse that ends the previous scan. The bench drives `sync_trig` in exactly that cycle and then requires `busy` to fall, with no strobe appearing after it. The two trigger sources can also arrive on one edge. An empty scan is started with both high, and its `done` must appear after the 6-cycle delay, not the 4-cycle one. Every strobe is matched against a schedule computed from the phase lengths, so one wrong cycle count anywhere shifts all later events.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_DSPL, PH_DCONV, PH_HOLD, PH_WAIT,
    PH_DIS, PH_SPL, PH_CONV, PH_SHEND, PH_SEND
  } phase_e;

  localparam logic [CNT_W-1:0] CONV_CLKS      = 8'd32;
  localparam logic [CNT_W-1:0] SETTLE_CLKS    = 8'd13;
  localparam logic [CNT_W-1:0] SH_END_CLKS    = 8'd3;
  localparam logic [CNT_W-1:0] SCAN_END_CLKS  = 8'd3;
  localparam logic [CNT_W-1:0] SYNC_DLY_CLKS  = 8'd6;
  localparam logic [CNT_W-1:0] SOFT_DLY_CLKS  = 8'd4;
  localparam logic [CNT_W-1:0] REF_SPL_CLKS   = 8'd15;

  // A programmed count of zero still occupies one cycle.
  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // Length in cycles of the phase about to be entered.
  function automatic logic [CNT_W-1:0] phase_len(
    input phase_e            ph,
    input logic [CNT_W-1:0]  spl,
    input logic [CNT_W-1:0]  hold,
    input logic [3:0]        dis,
    input logic [CNT_W-1:0]  diag,
    input logic              sync
  );
    case (ph)
      PH_START:          return sync ? SYNC_DLY_CLKS : SOFT_DLY_CLKS;
      PH_DSPL:           return at_least_one(diag);
      PH_DCONV, PH_CONV: return CONV_CLKS;
      PH_HOLD:           return at_least_one(hold);
      PH_WAIT:           return SETTLE_CLKS;
      PH_DIS:            return {4'b0, dis};
      PH_SPL:            return spl;
      PH_SHEND:          return SH_END_CLKS;
      PH_SEND:           return SCAN_END_CLKS;
      default:           return CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input  logic [NCH-1:0] pend,
  output logic           found,
  output logic [IW-1:0]  idx
);
  // Lowest pending channel wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_seq_splen.sv
module adc_seq_splen
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input  logic [NCH*CNT_W-1:0] spl_cfg,
  input  logic [IW-1:0]        ch,
  input  logic                 ref_en,
  input  logic [IW-1:0]        ref_ch,
  output logic [CNT_W-1:0]     len
);
  logic [CNT_W-1:0] cfg_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign cfg_a[g] = spl_cfg[g*CNT_W +: CNT_W];
  end

  logic is_ref;
  assign is_ref = ref_en && (ref_ch == ch);
  assign len    = is_ref ? REF_SPL_CLKS : at_least_one(cfg_a[ch]);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       ch_en,
  input  logic [NCH*CNT_W-1:0] spl_cfg,
  input  logic                 ref_en,
  input  logic [IW-1:0]        ref_ch,
  input  logic                 sh_en,
  input  logic [CNT_W-1:0]     sh_cfg,
  input  logic [3:0]           dis_cfg,
  input  logic                 diag_en,
  input  logic [CNT_W-1:0]     diag_cfg,
  input  logic                 sw_trig,
  input  logic                 sync_trig,
  output logic                 busy,
  output logic                 hold_stb,
  output logic                 samp_stb,
  output logic                 conv_stb,
  output logic                 res_valid,
  output logic                 res_diag,
  output logic [IW-1:0]        res_ch,
  output logic                 done
);

  phase_e           st_q, st_d;
  logic [NCH-1:0]   pend_q;
  logic             sh_q, diag_q, visited_q, first_q;
  logic [IW-1:0]    cur_q;

  // Named internal events
  logic             trig, accept, advance, take_ch, t_last, found;
  logic [IW-1:0]    sel_ch, len_ch;
  logic [CNT_W-1:0] spl_len, nxt_len;
  phase_e           entry_ph;

  assign trig    = sw_trig | sync_trig;
  assign accept  = (st_q == PH_IDLE) && trig;
  assign advance = (st_q == PH_IDLE) ? trig : t_last;

  adc_seq_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .pend  (pend_q),
    .found (found),
    .idx   (sel_ch)
  );

  assign len_ch = take_ch ? sel_ch : cur_q;

  adc_seq_splen #(.NCH(NCH), .IW(IW)) u_splen (
    .spl_cfg (spl_cfg),
    .ch      (len_ch),
    .ref_en  (ref_en),
    .ref_ch  (ref_ch),
    .len     (spl_len)
  );

  // Phase that follows when a channel is entered, or the scan tail.
  always_comb begin
    if (found) begin
      if (sh_q)                entry_ph = PH_HOLD;
      else if (dis_cfg != '0)  entry_ph = PH_DIS;
      else                     entry_ph = PH_SPL;
    end else begin
      entry_ph = (sh_q && visited_q) ? PH_SHEND : PH_SEND;
    end
  end

  always_comb begin
    st_d    = st_q;
    take_ch = 1'b0;
    case (st_q)
      PH_IDLE:  if (trig) st_d = PH_START;
      PH_START: if (t_last) begin
        if (diag_q) st_d = PH_DSPL;
        else begin
          st_d    = entry_ph;
          take_ch = found;
        end
      end
      PH_DSPL:  if (t_last) st_d = PH_DCONV;
      PH_DCONV, PH_CONV: if (t_last) begin
        st_d    = entry_ph;
        take_ch = found;
      end
      PH_HOLD:  if (t_last) st_d = PH_WAIT;
      PH_WAIT:  if (t_last) st_d = (dis_cfg != '0) ? PH_DIS : PH_SPL;
      PH_DIS:   if (t_last) st_d = PH_SPL;
      PH_SPL:   if (t_last) st_d = PH_CONV;
      PH_SHEND: if (t_last) st_d = PH_SEND;
      PH_SEND:  if (t_last) st_d = PH_IDLE;
      default:  st_d = PH_IDLE;
    endcase
  end

  assign nxt_len = phase_len(st_d, spl_len, sh_cfg, dis_cfg, diag_cfg, sync_trig);

  adc_seq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (advance),
    .len   (nxt_len),
    .last  (t_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PH_IDLE;
      first_q   <= 1'b0;
      pend_q    <= '0;
      sh_q      <= 1'b0;
      diag_q    <= 1'b0;
      visited_q <= 1'b0;
      cur_q     <= '0;
    end else begin
      first_q <= advance;
      if (advance) st_q <= st_d;
      if (accept) begin
        pend_q    <= ch_en;
        sh_q      <= sh_en;
        diag_q    <= diag_en;
        visited_q <= 1'b0;
      end else if (take_ch) begin
        pend_q[sel_ch] <= 1'b0;
        cur_q          <= sel_ch;
        visited_q      <= 1'b1;
      end
    end
  end

  assign busy      = (st_q != PH_IDLE);
  assign hold_stb  = first_q && (st_q == PH_HOLD);
  assign samp_stb  = first_q && ((st_q == PH_SPL) || (st_q == PH_DSPL));
  assign conv_stb  = first_q && ((st_q == PH_CONV) || (st_q == PH_DCONV));
  assign res_valid = t_last && ((st_q == PH_CONV) || (st_q == PH_DCONV));
  assign res_diag  = (st_q == PH_DCONV);
  assign res_ch    = cur_q;
  assign done      = t_last && (st_q == PH_SEND);

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_trig,
  input logic          sync_trig,
  input logic          busy,
  input logic          hold_stb,
  input logic          samp_stb,
  input logic          conv_stb,
  input logic          res_valid,
  input logic          res_diag,
  input logic [IW-1:0] res_ch,
  input logic          done
);
  logic [5:0]    age_q;
  logic          seen_q;
  logic [IW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      if (conv_stb)            age_q <= 6'd1;
      else if (age_q != 6'd63 && age_q != 6'd0) age_q <= age_q + 6'd1;
      if (done) seen_q <= 1'b0;
      else if (res_valid && !res_diag) begin
        seen_q <= 1'b1;
        last_q <= res_ch;
      end
    end
  end

  p_single_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hold_stb, samp_stb, conv_stb, res_valid, done}));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(hold_stb || samp_stb || conv_stb || res_valid || done));

  p_busy_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_start_needs_trig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sw_trig || sync_trig));

  p_conv_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (age_q == 6'd31));

  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_diag && seen_q) |-> (res_ch > last_q));

  p_diag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_diag) |-> !seen_q);

  p_done_in_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_trig   (sw_trig),
  .sync_trig (sync_trig),
  .busy      (busy),
  .hold_stb  (hold_stb),
  .samp_stb  (samp_stb),
  .conv_stb  (conv_stb),
  .res_valid (res_valid),
  .res_diag  (res_diag),
  .res_ch    (res_ch),
  .done      (done)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  localparam int NCH = 8;
  localparam int IW  = 3;
  localparam int K_HOLD = 0, K_SAMP = 1, K_CONV = 2, K_RES = 3, K_DONE = 4, K_DRES = 5;

  typedef struct { int kind; int ch; int t; string req; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0]   ch_en = '0;
  logic [NCH*8-1:0] spl_cfg = {NCH{8'h0D}};
  logic             ref_en = 1'b0;
  logic [IW-1:0]    ref_ch = '0;
  logic             sh_en = 1'b0;
  logic [7:0]       sh_cfg = 8'h1A;
  logic [3:0]       dis_cfg = 4'h0;
  logic             diag_en = 1'b0;
  logic [7:0]       diag_cfg = 8'h0D;
  logic             sw_trig = 1'b0, sync_trig = 1'b0;
  logic busy, hold_stb, samp_stb, conv_stb, res_valid, res_diag, done;
  logic [IW-1:0] res_ch;

  int compared = 0, mismatched = 0;
  int cyc = 0, acc_cyc = 0, t_done = 0;
  bit armed = 0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_scan_seq #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .spl_cfg(spl_cfg),
    .ref_en(ref_en), .ref_ch(ref_ch), .sh_en(sh_en), .sh_cfg(sh_cfg),
    .dis_cfg(dis_cfg), .diag_en(diag_en), .diag_cfg(diag_cfg),
    .sw_trig(sw_trig), .sync_trig(sync_trig), .busy(busy),
    .hold_stb(hold_stb), .samp_stb(samp_stb), .conv_stb(conv_stb),
    .res_valid(res_valid), .res_diag(res_diag), .res_ch(res_ch), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void push(int k, int c, int t, string r);
    exp_t e;
    e.kind = k; e.ch = c; e.t = t; e.req = r;
    q.push_back(e);
  endfunction

  function automatic int min1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Expected schedule, restated from the requirements.
  task automatic build(input logic sync);
    int t;
    bit any;
    q.delete();
    any = 0;
    t = sync ? 6 : 4;
    if (diag_en) begin
      push(K_SAMP, 0, t, "R3");
      t += min1(int'(diag_cfg));
      push(K_CONV, 0, t, "R3");
      t += 32;
      push(K_DRES, 0, t - 1, "R3");
    end
    for (int c = 0; c < NCH; c++) begin
      if (ch_en[c]) begin
        any = 1;
        if (sh_en) begin
          push(K_HOLD, c, t, "R8");
          t += min1(int'(sh_cfg)) + 13;
        end
        t += int'(dis_cfg);
        push(K_SAMP, c, t, (dis_cfg != 0) ? "R9" : "R5");
        t += (ref_en && ref_ch == c) ? 15 : min1(int'(spl_cfg[c*8 +: 8]));
        push(K_CONV, c, t, (ref_en && ref_ch == c) ? "R6" : "R5");
        t += 32;
        push(K_RES, c, t - 1, "R4 R7");
      end
    end
    if (sh_en && any) t += 3;
    t += 3;
    push(K_DONE, 0, t - 1, "R2 R10");
    t_done = t - 1;
  endtask

  // Monitor: pops expected items as strobes appear.
  always @(negedge clk) begin
    int n, k, rel;
    exp_t e;
    if (rst_n && armed) begin
      n = int'(hold_stb) + int'(samp_stb) + int'(conv_stb) + int'(res_valid) + int'(done);
      rel = cyc - acc_cyc;
      if (n > 1) begin
        check(0, "R11 strobes in one cycle", n, 1);
      end else if (n == 1) begin
        k = hold_stb ? K_HOLD : samp_stb ? K_SAMP : conv_stb ? K_CONV :
            res_valid ? (res_diag ? K_DRES : K_RES) : K_DONE;
        if (q.size() == 0) begin
          check(0, "R1 R11 unexpected strobe kind", k, -1);
        end else begin
          e = q.pop_front();
          compared++;
          if (e.kind != k || e.t != rel || (k == K_RES && e.ch != int'(res_ch))) begin
            mismatched++;
            $display("FAIL %s: actual kind %0d ch %0d t %0d expected kind %0d ch %0d t %0d",
                     e.req, k, res_ch, rel, e.kind, e.ch, e.t);
          end
        end
      end
    end
  end

  task automatic run_scan(input logic use_sw, input logic use_sync);
    build(use_sync);
    @(negedge clk);
    sw_trig = use_sw; sync_trig = use_sync;
    @(posedge clk); #1;
    acc_cyc = cyc;
    armed = 1;
    @(negedge clk);
    sw_trig = 0; sync_trig = 0;
    check(busy === 1'b1, "R1 busy after accept", busy, 1);
    while (cyc - acc_cyc < t_done) begin
      @(negedge clk);
      // R1: a request in mid-scan must be ignored
      sw_trig = (cyc - acc_cyc == 10) && (t_done > 12);
    end
    sw_trig = 0;
    check(busy === 1'b1, "R1 busy in done cycle", busy, 1);
    sync_trig = 1;                // R1: request in the done cycle
    @(negedge clk);
    sync_trig = 0;
    check(busy === 1'b0, "R1 busy drops after done", busy, 0);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 no restart from done-cycle request", busy, 0);
    check(q.size() == 0, "R10 all expected events seen", q.size(), 0);
  endtask

  initial begin
    #1_200_000;
    mismatched++;
    $display("FAIL R1: watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, hold_stb, samp_stb, conv_stb, res_valid, done} == 6'b0,
          "R11 reset outputs quiet", int'({busy, hold_stb, samp_stb, conv_stb, res_valid, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R7: sparse mask, software start, default counts
    ch_en = 8'b0010_0101;
    spl_cfg[2*8 +: 8] = 8'h05;
    run_scan(1'b1, 1'b0);

    // R3 R6 R8 R9 R2: everything on, synchronous start
    ch_en = 8'h81; sh_en = 1; sh_cfg = 8'h1A; dis_cfg = 4'd5;
    diag_en = 1; diag_cfg = 8'h0D; ref_en = 1; ref_ch = 3'd7;
    spl_cfg[0 +: 8] = 8'h20; spl_cfg[7*8 +: 8] = 8'h40;
    run_scan(1'b0, 1'b1);

    // R10: empty scan, software start
    ch_en = 8'h00; sh_en = 0; dis_cfg = 0; diag_en = 0; ref_en = 0;
    run_scan(1'b1, 1'b0);

    // R2 R8 R10: empty scan with hold enabled, both sources at once
    sh_en = 1;
    run_scan(1'b1, 1'b1);

    // R3 R5 R6: zero counts clamp to one, reference on a disabled channel
    sh_en = 0; ch_en = 8'b0000_0110; diag_en = 1; diag_cfg = 8'h00;
    ref_en = 1; ref_ch = 3'd0;
    spl_cfg[1*8 +: 8] = 8'h00; spl_cfg[2*8 +: 8] = 8'h03;
    run_scan(1'b1, 1'b0);

    // R6 R9: reference on an enabled channel, short assist, no hold
    ch_en = 8'b0001_1000; diag_en = 0; dis_cfg = 4'd1; ref_ch = 3'd4;
    spl_cfg[4*8 +: 8] = 8'hF0; spl_cfg[3*8 +: 8] = 8'h02;
    run_scan(1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule